// File: doc/BRIEF.md
# Generation-Tagged Event Queue Writer

This block appends 32-bit event words to a circular queue kept in system memory. Each request brings the queue geometry (a size code and a 60-bit base address split into a 28-bit high part and a 32-bit low part) and a control word. The control word holds the current write index in its low bits and the generation bit in bit 31. The block builds one stored word from the generation bit and 31 bits of event data. It issues a single memory write at the slot the index selects, and waits for the write response.

When the write succeeds, the block returns the control word with the index advanced. The generation bit is inverted whenever the index wraps to zero, so a consumer can tell fresh entries from stale ones without a shared tail pointer. When the memory reports an error, the enqueue is dropped and the control word comes back unchanged. The caller writes the returned word back into its descriptor storage. Only one enqueue is in flight at a time, and `busy` tells the caller when a new request may be presented.

Top module: `evq_writer`

## Requirements
- R1: The queue holds 2^(c+10) entries, where c is `req_size` clamped to MAX_SIZE_CODE (default 6). The index used is `req_ctrl[IDX_W-1:0]` (IDX_W = MAX_SIZE_CODE+10) modulo that entry count.
- R2: `mem_wr_addr` equals {`req_base_hi`, `req_base_lo`} plus four times the index used.
- R3: The logical stored word has the generation bit (`req_ctrl[31]`) in bit 31 and `req_data` in bits 30:0. It is placed big-endian on `mem_wr_data`: logical bits 31:24 on `mem_wr_data[7:0]`, 23:16 on [15:8], 15:8 on [23:16] and 7:0 on [31:24].
- R4: After a successful response, `done_ctrl[IDX_W-1:0]` holds (index used + 1) modulo the entry count, and `done_ctrl[30:IDX_W]` equals `req_ctrl[30:IDX_W]`.
- R5: After a successful response, `done_ctrl[31]` is the inverse of `req_ctrl[31]` when the advanced index is zero, and equal to it otherwise.
- R6: If the response has `mem_rsp_err` high, `done_err` is 1 and `done_ctrl` equals `req_ctrl` exactly; on success `done_err` is 0.
- R7: A request is accepted when `req_valid` is high while `busy` is low. `busy` is high from the cycle after acceptance until the response is taken. A request presented while `busy` is high causes no memory write.
- R8: `mem_wr_valid` rises in the cycle after acceptance and stays high with `mem_wr_addr` and `mem_wr_data` stable until `mem_wr_ready` is sampled high.
- R9: `done_valid` is a one-cycle pulse in the cycle after `mem_rsp_valid` is sampled high, and `busy` is low in that cycle.
- R10: During and right after reset, `busy`, `mem_wr_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Enqueue request |
| req_data | input | 31 | Event data |
| req_size | input | SIZE_W | Queue size code |
| req_base_hi | input | 28 | High part of the queue base address |
| req_base_lo | input | 32 | Low part of the queue base address |
| req_ctrl | input | 32 | Control word: generation in bit 31, index in low bits |
| busy | output | 1 | An enqueue is in flight |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 60 | Byte address of the write |
| mem_wr_data | output | 32 | Stored word, big-endian byte order |
| mem_rsp_valid | input | 1 | Write response |
| mem_rsp_err | input | 1 | Write failed |
| done_valid | output | 1 | Enqueue finished |
| done_err | output | 1 | Enqueue dropped on error |
| done_ctrl | output | 32 | Control word to write back |

## Verification
The hardest case to reach from the ports is the generation flip that follows a full lap of the queue. It needs about a thousand consecutive enqueues, each fed the previous `done_ctrl`, and an error response can land at the wrap slot and must leave both index and generation alone. The stimulus preloads indices at the last slot for several size codes, including a code above the clamp limit. It then runs a long random stream at the smallest size, seeded just below the end of the queue, so the stream wraps more than once. The stream mixes in random errors, ready stalls and response delays.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int BASE_HI_W = 28;
    localparam int BASE_LO_W = 32;
    localparam int ADDR_W    = BASE_HI_W + BASE_LO_W;
    localparam int WORD_W    = 32;
    localparam int EVT_W     = WORD_W - 1;
    localparam int LOG_MIN   = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_RESP  = 2'd2
    } evq_state_e;
endpackage

// File: rtl/evq_geom.sv
module evq_geom #(
    parameter int SIZE_W        = 4,
    parameter int MAX_SIZE_CODE = 6,
    parameter int IDX_W         = MAX_SIZE_CODE + evq_pkg::LOG_MIN
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic [IDX_W-1:0]  idx_mask
);
    logic [SIZE_W-1:0] eff_code;

    // codes beyond the supported range use the largest queue
    assign eff_code = (size_code > SIZE_W'(MAX_SIZE_CODE)) ? SIZE_W'(MAX_SIZE_CODE) : size_code;

    for (genvar i = 0; i < IDX_W; i++) begin : g_mask
        assign idx_mask[i] = (int'(eff_code) + evq_pkg::LOG_MIN) > i;
    end
endmodule

// File: rtl/evq_format.sv
module evq_format #(
    parameter int IDX_W = 16
) (
    input  logic [evq_pkg::BASE_HI_W-1:0] base_hi,
    input  logic [evq_pkg::BASE_LO_W-1:0] base_lo,
    input  logic [IDX_W-1:0]              idx_cur,
    input  logic                          gen,
    input  logic [evq_pkg::EVT_W-1:0]     data,
    output logic [evq_pkg::ADDR_W-1:0]    addr,
    output logic [evq_pkg::WORD_W-1:0]    bus_word
);
    localparam int PAD_W  = evq_pkg::ADDR_W - IDX_W - 2;
    localparam int BYTES  = evq_pkg::WORD_W / 8;

    logic [evq_pkg::WORD_W-1:0] word;

    assign addr = {base_hi, base_lo} + {{PAD_W{1'b0}}, idx_cur, 2'b00};
    assign word = {gen, data};

    // most significant byte goes to the lowest byte lane
    for (genvar b = 0; b < BYTES; b++) begin : g_swap
        assign bus_word[8*b +: 8] = word[8*(BYTES-1-b) +: 8];
    end
endmodule

// File: rtl/evq_advance.sv
module evq_advance #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] idx_cur,
    input  logic [IDX_W-1:0] idx_mask,
    input  logic             gen_in,
    output logic [IDX_W-1:0] idx_next,
    output logic             gen_next
);
    logic [IDX_W-1:0] inc;

    assign inc      = idx_cur + IDX_W'(1);
    assign idx_next = inc & idx_mask;
    assign gen_next = gen_in ^ (idx_next == '0);
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
    import evq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [WORD_W-1:0]   acc_wdata,
    input  logic [WORD_W-1:0]   acc_ctrl_ok,
    input  logic [WORD_W-1:0]   acc_ctrl_orig,
    output logic                busy,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [WORD_W-1:0]   mem_wr_data,
    input  logic                mem_rsp_valid,
    input  logic                mem_rsp_err,
    output logic                done_valid,
    output logic                done_err,
    output logic [WORD_W-1:0]   done_ctrl
);
    typedef struct packed {
        evq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] ctrl_ok;
        logic [WORD_W-1:0] ctrl_orig;
        logic              done_valid;
        logic              done_err;
        logic [WORD_W-1:0] done_ctrl;
    } ctrl_regs_t;

    ctrl_regs_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.done_valid = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.state     = ST_WRITE;
                    st_d.addr      = acc_addr;
                    st_d.wdata     = acc_wdata;
                    st_d.ctrl_ok   = acc_ctrl_ok;
                    st_d.ctrl_orig = acc_ctrl_orig;
                end
            end
            ST_WRITE: begin
                if (mem_wr_ready) begin
                    st_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                if (mem_rsp_valid) begin
                    st_d.state      = ST_IDLE;
                    st_d.done_valid = 1'b1;
                    st_d.done_err   = mem_rsp_err;
                    // a failed write leaves index and generation untouched
                    st_d.done_ctrl  = mem_rsp_err ? st_q.ctrl_orig : st_q.ctrl_ok;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = (st_q.state != ST_IDLE);
    assign mem_wr_valid = (st_q.state == ST_WRITE);
    assign mem_wr_addr  = st_q.addr;
    assign mem_wr_data  = st_q.wdata;
    assign done_valid   = st_q.done_valid;
    assign done_err     = st_q.done_err;
    assign done_ctrl    = st_q.done_ctrl;
endmodule

// File: rtl/evq_writer.sv
module evq_writer
    import evq_pkg::*;
#(
    parameter int SIZE_W        = 4,
    parameter int MAX_SIZE_CODE = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [EVT_W-1:0]     req_data,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic [BASE_HI_W-1:0] req_base_hi,
    input  logic [BASE_LO_W-1:0] req_base_lo,
    input  logic [WORD_W-1:0]    req_ctrl,
    output logic                 busy,
    output logic                 mem_wr_valid,
    input  logic                 mem_wr_ready,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [WORD_W-1:0]    mem_wr_data,
    input  logic                 mem_rsp_valid,
    input  logic                 mem_rsp_err,
    output logic                 done_valid,
    output logic                 done_err,
    output logic [WORD_W-1:0]    done_ctrl
);
    localparam int IDX_W = MAX_SIZE_CODE + LOG_MIN;

    logic [IDX_W-1:0]  idx_mask;
    logic [IDX_W-1:0]  idx_cur;
    logic [IDX_W-1:0]  idx_next;
    logic              gen_next;
    logic [ADDR_W-1:0] slot_addr;
    logic [WORD_W-1:0] slot_word;
    logic [WORD_W-1:0] ctrl_ok;

    evq_geom #(
        .SIZE_W        (SIZE_W),
        .MAX_SIZE_CODE (MAX_SIZE_CODE),
        .IDX_W         (IDX_W)
    ) u_geom (
        .size_code (req_size),
        .idx_mask  (idx_mask)
    );

    assign idx_cur = req_ctrl[IDX_W-1:0] & idx_mask;

    evq_format #(
        .IDX_W (IDX_W)
    ) u_format (
        .base_hi  (req_base_hi),
        .base_lo  (req_base_lo),
        .idx_cur  (idx_cur),
        .gen      (req_ctrl[WORD_W-1]),
        .data     (req_data),
        .addr     (slot_addr),
        .bus_word (slot_word)
    );

    evq_advance #(
        .IDX_W (IDX_W)
    ) u_advance (
        .idx_cur  (idx_cur),
        .idx_mask (idx_mask),
        .gen_in   (req_ctrl[WORD_W-1]),
        .idx_next (idx_next),
        .gen_next (gen_next)
    );

    assign ctrl_ok = {gen_next, req_ctrl[WORD_W-2:IDX_W], idx_next};

    evq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .acc_addr      (slot_addr),
        .acc_wdata     (slot_word),
        .acc_ctrl_ok   (ctrl_ok),
        .acc_ctrl_orig (req_ctrl),
        .busy          (busy),
        .mem_wr_valid  (mem_wr_valid),
        .mem_wr_ready  (mem_wr_ready),
        .mem_wr_addr   (mem_wr_addr),
        .mem_wr_data   (mem_wr_data),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .done_valid    (done_valid),
        .done_err      (done_err),
        .done_ctrl     (done_ctrl)
    );
endmodule

// File: rtl/evq_checker.sv
module evq_checker #(
    parameter int IDX_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_ctrl,
    input logic        busy,
    input logic        mem_wr_valid,
    input logic        mem_wr_ready,
    input logic [59:0] mem_wr_addr,
    input logic [31:0] mem_wr_data,
    input logic        done_valid,
    input logic        done_err,
    input logic [31:0] done_ctrl
);
    logic [31:0] cap_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ctrl <= '0;
        end else if (req_valid && !busy) begin
            cap_ctrl <= req_ctrl;
        end
    end

    a_r6_err_restores: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_err |-> done_ctrl == cap_ctrl);

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_err |-> done_ctrl[30:IDX_W] == cap_ctrl[30:IDX_W]);

    a_r8_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

    a_r7_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> busy);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !busy);
endmodule

bind evq_writer evq_checker #(
    .IDX_W (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ctrl     (req_ctrl),
    .busy         (busy),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .done_valid   (done_valid),
    .done_err     (done_err),
    .done_ctrl    (done_ctrl)
);

// File: tb/evq_writer_test.sv
`timescale 1ns/1ps
module evq_writer_test;
    localparam int SIZE_W = 4;
    localparam int MAXC   = 6;
    localparam int IW     = MAXC + 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [30:0] req_data = '0;
    logic [3:0]  req_size = '0;
    logic [27:0] req_base_hi = '0;
    logic [31:0] req_base_lo = '0;
    logic [31:0] req_ctrl = '0;
    logic        busy;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [59:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic        done_valid;
    logic        done_err;
    logic [31:0] done_ctrl;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    evq_writer #(.SIZE_W(SIZE_W), .MAX_SIZE_CODE(MAXC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_size(req_size), .req_base_hi(req_base_hi), .req_base_lo(req_base_lo),
        .req_ctrl(req_ctrl), .busy(busy), .mem_wr_valid(mem_wr_valid),
        .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .done_valid(done_valid), .done_err(done_err), .done_ctrl(done_ctrl)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] f_mask(input logic [3:0] s);
        int e;
        e = (int'(s) > MAXC) ? MAXC : int'(s);
        return IW'((32'd1 << (e + 10)) - 1);
    endfunction

    function automatic logic [59:0] f_addr(input logic [27:0] hi, input logic [31:0] lo,
                                           input logic [31:0] ctrl, input logic [3:0] s);
        logic [59:0] off;
        off = 60'(ctrl[IW-1:0] & f_mask(s)) * 60'd4;
        return {hi, lo} + off;
    endfunction

    function automatic logic [31:0] f_bus(input logic g, input logic [30:0] d);
        logic [31:0] w;
        w = {g, d};
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] f_next(input logic [31:0] ctrl, input logic [3:0] s);
        logic [IW-1:0] m, cur, nx;
        logic g;
        m   = f_mask(s);
        cur = ctrl[IW-1:0] & m;
        nx  = (cur + IW'(1)) & m;
        g   = ctrl[31] ^ (nx == '0);
        return {g, ctrl[30:IW], nx};
    endfunction

    task automatic enq(input logic [31:0] ctrl, input logic [30:0] data, input logic [3:0] s,
                       input logic [27:0] hi, input logic [31:0] lo, input bit err,
                       input int wdly, input int rdly, input bit poke,
                       output logic [31:0] result, input string tag);
        logic [31:0] exp_ctrl;
        int n;
        exp_ctrl = err ? ctrl : f_next(ctrl, s);
        @(negedge clk);
        req_valid = 1'b1; req_data = data; req_size = s;
        req_base_hi = hi; req_base_lo = lo; req_ctrl = ctrl;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {"R7 busy after accept ", tag}, 64'(busy), 64'd1);
        if (poke) begin
            req_valid = 1'b1; req_data = ~data; req_ctrl = ctrl + 32'd5;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!mem_wr_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(mem_wr_valid == 1'b1, {"R8 write valid ", tag}, 64'(mem_wr_valid), 64'd1);
        repeat (wdly) @(negedge clk);
        chk(mem_wr_valid == 1'b1, {"R8 write held ", tag}, 64'(mem_wr_valid), 64'd1);
        chk(mem_wr_addr == f_addr(hi, lo, ctrl, s), {"R2 addr ", tag}, 64'(mem_wr_addr), 64'(f_addr(hi, lo, ctrl, s)));
        chk(mem_wr_data == f_bus(ctrl[31], data), {"R3 data ", tag}, 64'(mem_wr_data), 64'(f_bus(ctrl[31], data)));
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        repeat (rdly) @(negedge clk);
        chk(busy == 1'b1 && mem_wr_valid == 1'b0, {"R7 waiting response ", tag},
            64'({busy, mem_wr_valid}), 64'd2);
        mem_rsp_valid = 1'b1; mem_rsp_err = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
        chk(done_valid == 1'b1, {"R9 done pulse ", tag}, 64'(done_valid), 64'd1);
        chk(busy == 1'b0, {"R9 idle at done ", tag}, 64'(busy), 64'd0);
        chk(done_err == err, {"R6 done_err ", tag}, 64'(done_err), 64'(err));
        chk(done_ctrl == exp_ctrl, {err ? "R6 ctrl kept " : "R4 R5 ctrl next ", tag},
            64'(done_ctrl), 64'(exp_ctrl));
        result = done_ctrl;
        @(negedge clk);
        chk(done_valid == 1'b0, {"R9 done single ", tag}, 64'(done_valid), 64'd0);
        if (poke) begin
            repeat (3) begin
                chk(mem_wr_valid == 1'b0 && busy == 1'b0, {"R7 busy request ignored ", tag},
                    64'({mem_wr_valid, busy}), 64'd0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R9 watchdog expired act=%0d exp=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] res, c;
        void'($urandom(32'd31337));
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_wr_valid == 0 && done_valid == 0, "R10 in reset",
            64'({busy, mem_wr_valid, done_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && mem_wr_valid == 0 && done_valid == 0, "R10 after reset",
            64'({busy, mem_wr_valid, done_valid}), 64'd0);

        // R5 last slot of smallest queue wraps and flips generation
        enq(32'h0000_03FF, 31'h1234_5678, 4'd0, 28'h0AB_CDEF, 32'h1000_0000, 0, 0, 0, 0, res, "R5 wrap c0");
        chk(res == 32'h8000_0000, "R5 gen set on wrap", 64'(res), 64'h8000_0000);
        // R5 generation clears on the next lap
        enq(32'h8000_03FF, 31'h7FFF_FFFF, 4'd0, 28'h0, 32'h0, 0, 2, 1, 0, res, "R5 wrap back");
        chk(res == 32'h0000_0000, "R5 gen cleared on wrap", 64'(res), 64'h0);
        // R1 index bits above the entry count are ignored
        enq(32'h0000_0500, 31'h0000_00AA, 4'd0, 28'hFFF_FFFF, 32'hFFFF_FF00, 0, 1, 0, 0, res, "R1 masked idx");
        // R1 size code above the limit is clamped
        enq(32'h4000_FFFF, 31'h0055_AA00, 4'd9, 28'h000_0001, 32'h0, 0, 0, 0, 0, res, "R1 clamp");
        enq(32'h0000_7FFF, 31'h0000_0001, 4'd5, 28'h0, 32'h8000_0000, 0, 0, 0, 0, res, "R1 c5 wrap");
        enq(32'h1234_0123, 31'h0ABC_DEF0, 4'd3, 28'h123_4567, 32'h89AB_CDEF, 0, 0, 0, 0, res, "R4 upper kept");
        // R6 error at the wrap slot keeps everything
        enq(32'h8000_03FF, 31'h0000_0042, 4'd0, 28'h0, 32'h4000, 1, 1, 2, 0, res, "R6 err at wrap");
        // R7 a request while busy is dropped
        enq(32'h0000_0010, 31'h0000_0077, 4'd0, 28'h0, 32'h0, 0, 2, 1, 1, res, "R7 poke");

        // random stream on the smallest queue, wrapping more than once
        c = {1'b0, 15'($urandom), 16'd1000};
        for (int i = 0; i < 2200; i++) begin
            enq(c, 31'($urandom), 4'd0, 28'h00C_0000, 32'h0001_0000, ($urandom % 8) == 0,
                int'($urandom % 3), int'($urandom % 3), 0, res, "R5 stream");
            c = res;
        end
        // random geometry
        for (int i = 0; i < 200; i++) begin
            enq($urandom, 31'($urandom), 4'($urandom), 28'($urandom), $urandom, ($urandom % 6) == 0,
                int'($urandom % 3), int'($urandom % 3), ($urandom % 10) == 0, res, "R1 R2 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule